// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block is a two-way data path between an A side and a B side, each WIDTH channels wide (18 by default). Data travelling in each direction passes through one storage path. That path acts in one of three ways: as a transparent wire while its pass control is high, as a level-sensitive latch once the pass control drops, or as an edge-triggered register clocked by a device clock and gated by an active-low tick enable.

Each direction has its own four controls: an active-low drive control, a pass control, a device clock and a tick enable. The A-to-B path feeds `b_out` and the B-to-A path feeds `a_out`. Neither side has a tri-state pin. Each output carries a companion drive flag, and a bus owner outside the block turns that flag into real tri-state control.

All storage is held in registers clocked by the system clock `clk`. The device clock and the pass control are treated as sampled inputs, and the device clock must be slower than `clk`. A rising edge of the device clock is seen in the first `clk` cycle in which it reads high after having read low. Reset is synchronous and active high.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While a direction's pass control is high, its output equals its input in the same cycle, whatever the device clock and tick enable do.
- R2: With pass low and tick enable low (0 = enabled), a device clock that reads 1 in a `clk` cycle after reading 0 in the previous one stores the input at that `clk` edge. The output shows the stored value from then on.
- R3: With tick enable high, device clock edges store nothing and the output keeps its value while pass is low.
- R4: With pass low and no qualifying device clock rise, including a device clock held at 1 or at 0, the stored value and the output do not change.
- R5: When pass falls, the value held is the input present in the last cycle in which pass was high. This applies even with the device clock high.
- R6: A drive flag is 1 only when its drive control is 0 (0 = drive) and reset has been released for at least one cycle. A drive control of 1 clears the flag.
- R7: Storage keeps updating by R2 and R5 while the drive flag is 0.
- R8: The two directions are independent. Controls and data of one direction never change the other direction's output.
- R9: Reset clears both storage registers to zero and holds both drive flags at 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | A-side data into the A-to-B path |
| b_in | input | WIDTH | B-side data into the B-to-A path |
| ab_drv_n | input | 1 | A-to-B drive control, 0 = drive |
| ab_open | input | 1 | A-to-B pass control, 1 = transparent |
| ab_tick | input | 1 | A-to-B device clock |
| ab_tick_en_n | input | 1 | A-to-B tick enable, 0 = edges store |
| ba_drv_n | input | 1 | B-to-A drive control, 0 = drive |
| ba_open | input | 1 | B-to-A pass control, 1 = transparent |
| ba_tick | input | 1 | B-to-A device clock |
| ba_tick_en_n | input | 1 | B-to-A tick enable, 0 = edges store |
| b_out | output | WIDTH | B-side output data |
| b_drive | output | 1 | B-side drive flag |
| a_out | output | WIDTH | A-side output data |
| a_drive | output | 1 | A-side drive flag |

## Verification
The hardest situation to reach is a latch that closes while the device clock is already high. If this case is handled wrongly, a stale or later value gets held, or a false edge is taken. To reach it, the stimulus raises the device clock while the path is transparent, keeps it high while pass falls, and then changes the input, so that only the value from before the close can appear. A second hard situation is a capture made while the outputs are not driven. This is reached by clocking new data in with the drive control high, and then checking the data once driving resumes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Output selection: transparent path or held value.
  function automatic logic [63:0] pick_out(input logic open, input logic [63:0] din,
                                           input logic [63:0] held);
    return open ? din : held;
  endfunction

  // Rising edge of a sampled level.
  function automatic logic rising(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  // Whether storage loads on this system clock cycle.
  function automatic logic loads(input logic open, input logic en_n, input logic rise);
    return open | (~en_n & rise);
  endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic level,
  output logic rise
);
  import xcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= level;
  end

  assign rise = rising(level, prev_q);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open,
  input  logic             en_n,
  input  logic             rise,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] held,
  output logic             load
);
  import xcvr_pkg::*;

  assign load = loads(open, en_n, rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (load) begin
      held <= din;
    end
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drv_n,
  input  logic             open,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  import xcvr_pkg::*;

  localparam int PADW = 64 - WIDTH;

  logic        live_q;
  logic [63:0] sel;

  always_ff @(posedge clk) begin
    live_q <= ~rst;
  end

  assign sel   = pick_out(open, {{PADW{1'b0}}, din}, {{PADW{1'b0}}, held});
  assign dout  = sel[WIDTH-1:0];
  assign drive = live_q & ~rst & ~drv_n;
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_drv_n,
  input  logic             ab_open,
  input  logic             ab_tick,
  input  logic             ab_tick_en_n,
  input  logic             ba_drv_n,
  input  logic             ba_open,
  input  logic             ba_tick,
  input  logic             ba_tick_en_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive
);
  localparam int NDIR = 2;

  logic [NDIR-1:0]            drv_n, open, tick, en_n;
  logic [NDIR-1:0][WIDTH-1:0] din, dout, held;
  logic [NDIR-1:0]            drive;
  // Internal events brought out for the checker
  logic [NDIR-1:0]            tick_rise;
  logic [NDIR-1:0]            store_load;

  // Index 0: A-to-B, index 1: B-to-A
  assign drv_n = {ba_drv_n, ab_drv_n};
  assign open  = {ba_open, ab_open};
  assign tick  = {ba_tick, ab_tick};
  assign en_n  = {ba_tick_en_n, ab_tick_en_n};
  assign din   = {b_in, a_in};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_edge_det u_edge (
      .clk   (clk),
      .level (tick[d]),
      .rise  (tick_rise[d])
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk  (clk),
      .rst  (rst),
      .open (open[d]),
      .en_n (en_n[d]),
      .rise (tick_rise[d]),
      .din  (din[d]),
      .held (held[d]),
      .load (store_load[d])
    );

    xcvr_drive #(.WIDTH(WIDTH)) u_drive (
      .clk   (clk),
      .rst   (rst),
      .drv_n (drv_n[d]),
      .open  (open[d]),
      .din   (din[d]),
      .held  (held[d]),
      .dout  (dout[d]),
      .drive (drive[d])
    );
  end

  assign b_out   = dout[0];
  assign b_drive = drive[0];
  assign a_out   = dout[1];
  assign a_drive = drive[1];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             ab_drv_n,
  input logic             ab_open,
  input logic             ab_tick_en_n,
  input logic             ba_drv_n,
  input logic             ba_open,
  input logic             ba_tick_en_n,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic             ab_rise,
  input logic             ba_rise
);
  AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst) ab_open |-> b_out == a_in); // R1
  AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst) ba_open |-> a_out == b_in); // R1
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ab_open && !ab_tick_en_n && ab_rise) |=> (ab_open || b_out == $past(a_in))); // R2
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ba_open && !ba_tick_en_n && ba_rise) |=> (ba_open || a_out == $past(b_in))); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_open && (ab_tick_en_n || !ab_rise)) |=> (ab_open || $stable(b_out))); // R4
  AST_BA_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (!ba_open && ba_tick_en_n) |=> (ba_open || $stable(a_out))); // R3
  AST_AB_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (ab_open) |=> (ab_open || b_out == $past(a_in))); // R5
  AST_AB_DRIVE: assert property (@(posedge clk) disable iff (rst) b_drive |-> !ab_drv_n); // R6
  AST_BA_DRIVE: assert property (@(posedge clk) disable iff (rst) a_drive |-> !ba_drv_n); // R6
  AST_RST_QUIET: assert property (@(posedge clk) rst |-> (!a_drive && !b_drive)); // R9
endmodule

bind bidir_latch_xcvr xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .a_in         (a_in),
  .b_in         (b_in),
  .ab_drv_n     (ab_drv_n),
  .ab_open      (ab_open),
  .ab_tick_en_n (ab_tick_en_n),
  .ba_drv_n     (ba_drv_n),
  .ba_open      (ba_open),
  .ba_tick_en_n (ba_tick_en_n),
  .b_out        (b_out),
  .b_drive      (b_drive),
  .a_out        (a_out),
  .a_drive      (a_drive),
  .ab_rise      (tick_rise[0]),
  .ba_rise      (tick_rise[1])
);

// File: tb/sim_bidir_latch_xcvr.sv
`timescale 1ns/1ps
module sim_bidir_latch_xcvr;
  localparam int W = 18;
  localparam int NV = 14;

  typedef struct packed {
    logic         open;
    logic         en_n;
    logic         tick;
    logic [W-1:0] din;
    logic [W-1:0] expv;
    logic [3:0]   req;
  } vec_t;

  // Each row is applied at a falling clk edge and checked at the next one.
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b1, 1'b0, 18'h2A5A5, 18'h2A5A5, 4'd1},
    '{1'b1, 1'b0, 1'b1, 18'h15A5A, 18'h15A5A, 4'd1},
    '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h15A5A, 4'd5},
    '{1'b0, 1'b0, 1'b1, 18'h00001, 18'h15A5A, 4'd4},
    '{1'b0, 1'b0, 1'b0, 18'h00002, 18'h15A5A, 4'd4},
    '{1'b0, 1'b0, 1'b1, 18'h12345, 18'h12345, 4'd2},
    '{1'b0, 1'b0, 1'b1, 18'h00F0F, 18'h12345, 4'd4},
    '{1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h12345, 4'd4},
    '{1'b0, 1'b1, 1'b1, 18'h3C3C3, 18'h12345, 4'd3},
    '{1'b0, 1'b1, 1'b0, 18'h3C3C3, 18'h12345, 4'd3},
    '{1'b0, 1'b1, 1'b1, 18'h0AAAA, 18'h12345, 4'd3},
    '{1'b0, 1'b0, 1'b0, 18'h0AAAA, 18'h12345, 4'd4},
    '{1'b0, 1'b0, 1'b1, 18'h20001, 18'h20001, 4'd2},
    '{1'b1, 1'b1, 1'b0, 18'h11111, 18'h11111, 4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_drv_n = 1'b1, ab_open = 1'b0, ab_tick = 1'b0, ab_tick_en_n = 1'b1;
  logic ba_drv_n = 1'b1, ba_open = 1'b0, ba_tick = 1'b0, ba_tick_en_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_latch_xcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_drv_n(ab_drv_n), .ab_open(ab_open), .ab_tick(ab_tick), .ab_tick_en_n(ab_tick_en_n),
    .ba_drv_n(ba_drv_n), .ba_open(ba_open), .ba_tick(ba_tick), .ba_tick_en_n(ba_tick_en_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic set_dir(input int dir, input logic op, input logic en, input logic tk,
                         input logic [W-1:0] d);
    if (dir == 0) begin
      ab_open = op; ab_tick_en_n = en; ab_tick = tk; a_in = d;
    end else begin
      ba_open = op; ba_tick_en_n = en; ba_tick = tk; b_in = d;
    end
  endtask

  function automatic logic [W-1:0] out_of(input int dir);
    return (dir == 0) ? b_out : a_out;
  endfunction

  function automatic logic drv_of(input int dir);
    return (dir == 0) ? b_drive : a_drive;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 18'h0, 18'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] other;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(b_drive == 1'b0 && a_drive == 1'b0, "R9 drive in reset", {17'h0, b_drive | a_drive}, '0);
    check(b_out == '0, "R9 b_out cleared", b_out, '0);
    check(a_out == '0, "R9 a_out cleared", a_out, '0);
    rst = 1'b0;
    ab_drv_n = 1'b0; ba_drv_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(b_drive == 1'b1 && a_drive == 1'b1, "R6 drive after reset", {17'h0, b_drive & a_drive}, 18'h1);

    // Vector table, once per direction; the other direction idles closed and inhibited.
    for (int dir = 0; dir < 2; dir++) begin
      other = out_of(1 - dir);
      for (int i = 0; i < NV; i++) begin
        set_dir(dir, VT[i].open, VT[i].en_n, VT[i].tick, VT[i].din);
        #0.5;
        if (VT[i].open)
          check(out_of(dir) == VT[i].din, "R1 same-cycle pass", out_of(dir), VT[i].din);
        @(negedge clk);
        check(out_of(dir) == VT[i].expv, $sformatf("R%0d vector %0d dir %0d", VT[i].req, i, dir),
              out_of(dir), VT[i].expv);
      end
      check(out_of(1 - dir) == other, "R8 other direction untouched", out_of(1 - dir), other);
      check(drv_of(dir) == 1'b1, "R6 drive with control low", {17'h0, drv_of(dir)}, 18'h1);
      set_dir(dir, 1'b0, 1'b1, 1'b0, '0);
      @(negedge clk);
    end

    // R6/R7: disable A-to-B drive, capture while undriven, then re-enable
    ab_drv_n = 1'b1;
    set_dir(0, 1'b0, 1'b0, 1'b0, 18'h0BEEF);
    @(negedge clk);
    check(b_drive == 1'b0, "R6 drive off", {17'h0, b_drive}, '0);
    set_dir(0, 1'b0, 1'b0, 1'b1, 18'h0BEEF);
    @(negedge clk);
    set_dir(0, 1'b0, 1'b0, 1'b1, 18'h00000);
    ab_drv_n = 1'b0;
    @(negedge clk);
    check(b_out == 18'h0BEEF, "R7 capture while undriven", b_out, 18'h0BEEF);
    check(b_drive == 1'b1, "R6 drive back on", {17'h0, b_drive}, 18'h1);

    // R5 on B-to-A: close with device clock low, then change input
    set_dir(1, 1'b1, 1'b1, 1'b0, 18'h2468A);
    @(negedge clk);
    set_dir(1, 1'b0, 1'b1, 1'b0, 18'h13579);
    @(negedge clk);
    check(a_out == 18'h2468A, "R5 close with clock low", a_out, 18'h2468A);

    // R9: reset again clears held data
    rst = 1'b1;
    @(negedge clk);
    check(a_out == '0 && b_out == '0, "R9 reset clears storage", a_out | b_out, '0);
    check(a_drive == 1'b0, "R9 drive low in reset", {17'h0, a_drive}, '0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule